// File: doc/BRIEF.md
# Management Mode Active Sequencer

This block orders the entry into and the exit from system management mode, and it drives the active signal that outside logic uses to decode the private save-state memory. A single-cycle take request starts the entry. The sequencer then waits until all posted writes have drained. Only after that does it raise the active signal and issue a one-cycle go-ahead that lets the bus logic start the state save. The active signal stays high through the save, through the handler and through the restore. It drops only after the last restore read has completed. A bus HOLD request has no effect on it, because the output is always driven.

Two span counters measure the time spent in the entry phase and in the exit phase. Entry covers the drain cycles plus the save cycles. Exit covers the restore cycles. Each counter compares its result with a minimum: 161 clocks for entry and 258 clocks for exit by default. A test environment can then flag a sequence that ran impossibly fast. A sticky ordering flag reports a first save write that is seen while the active signal is still low.

Top module: `mm_active_seq`

## Requirements
- R1: After reset, mmActive, saveGo, orderErr, entryShort and exitShort are 0, and entryCycles and exitCycles are 0.
- R2: After a take request is accepted in the idle state, mmActive stays 0 for as long as wbEmpty is sampled 0.
- R3: In the cycle that follows the clock edge at which wbEmpty is sampled 1 during draining, saveGo is 1 for exactly one cycle, and mmActive rises in that same cycle.
- R4: Once raised, mmActive stays 1 through the save, handler and restore phases. It falls in the cycle after lastRestoreRd is sampled during restore.
- R5: holdReq has no effect on mmActive.
- R6: At handler entry, which is saveDone sampled during the save phase, entryCycles becomes the number of cycles spent draining plus saving. entryShort becomes 1 when that number is below ENTRY_MIN (default 161) and 0 otherwise.
- R7: When lastRestoreRd is sampled during restore, exitCycles becomes the number of cycles spent in restore, counted from the cycle after resumeReq is sampled in the handler. exitShort becomes 1 when that number is below EXIT_MIN (default 258) and 0 otherwise.
- R8: A take request that is sampled outside the idle state is ignored. It also has no effect when it coincides with the final restore read.
- R9: orderErr is set, and then stays set until reset, when firstSaveWr is sampled while mmActive is 0.
- R10: entryCycles and exitCycles keep their values between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| takeReq | input | 1 | Single-cycle request to enter management mode |
| wbEmpty | input | 1 | All posted writes are complete and the write buffers are empty |
| firstSaveWr | input | 1 | Strobe: the first save-state write is starting |
| saveDone | input | 1 | Strobe: the state save is finished and the handler starts |
| resumeReq | input | 1 | Strobe: the handler has issued resume |
| lastRestoreRd | input | 1 | Strobe: the last restore read has completed |
| holdReq | input | 1 | Bus HOLD request from another master |
| mmActive | output | 1 | Management mode active, used to decode the private memory |
| saveGo | output | 1 | One-cycle go-ahead to start the state save |
| orderErr | output | 1 | Sticky flag: save write seen while inactive |
| entryShort | output | 1 | Last entry span was below ENTRY_MIN |
| exitShort | output | 1 | Last exit span was below EXIT_MIN |
| entryCycles | output | CNT_W | Last measured entry span in clocks |
| exitCycles | output | CNT_W | Last measured exit span in clocks |

## Verification
Two events can land in the same cycle: a new take request and the final restore read. When they do, the request must not restart the sequence. The bench provokes this by pulsing takeReq on the same edge as lastRestoreRd, with wbEmpty held high. It then judges the outcome by requiring mmActive to fall on the next cycle and by requiring that saveGo never pulses in the cycles after it. A second pairing drives holdReq on the same edges that carry the handler and restore strobes, and the bench expects mmActive to behave exactly as it does without HOLD.

// File: rtl/mm_seq_pkg.sv
package mm_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_SAVE    = 3'd2,
    ST_HANDLER = 3'd3,
    ST_RESTORE = 3'd4
  } seqState_t;

  typedef struct packed {
    logic clrEntry;
    logic incEntry;
    logic latchEntry;
    logic clrExit;
    logic incExit;
    logic latchExit;
  } spanStrobes_t;

endpackage

// File: rtl/mm_seq_ctrl.sv
module mm_seq_ctrl
  import mm_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         takeReq,
  input  logic         wbEmpty,
  input  logic         firstSaveWr,
  input  logic         saveDone,
  input  logic         resumeReq,
  input  logic         lastRestoreRd,
  input  logic         holdReq,
  output logic         mmActive,
  output logic         saveGo,
  output logic         orderErr,
  output spanStrobes_t strobes
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (takeReq)       stateNext = ST_DRAIN;
      ST_DRAIN:   if (wbEmpty)       stateNext = ST_SAVE;
      ST_SAVE:    if (saveDone)      stateNext = ST_HANDLER;
      ST_HANDLER: if (resumeReq)     stateNext = ST_RESTORE;
      ST_RESTORE: if (lastRestoreRd) stateNext = ST_IDLE;
      default:                       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      mmActive <= 1'b0;
      saveGo   <= 1'b0;
      orderErr <= 1'b0;
    end else begin
      state    <= stateNext;
      mmActive <= (stateNext == ST_SAVE) || (stateNext == ST_HANDLER) ||
                  (stateNext == ST_RESTORE);
      saveGo   <= (state == ST_DRAIN) && wbEmpty;
      if (firstSaveWr && !mmActive) orderErr <= 1'b1;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.clrEntry   = (state == ST_IDLE) && takeReq;
    strobes.incEntry   = (state == ST_DRAIN) || (state == ST_SAVE);
    strobes.latchEntry = (state == ST_SAVE) && saveDone;
    strobes.clrExit    = (state == ST_HANDLER) && resumeReq;
    strobes.incExit    = (state == ST_RESTORE);
    strobes.latchExit  = (state == ST_RESTORE) && lastRestoreRd;
  end

  // R2
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !wbEmpty) |=> !mmActive);

  // R3
  go_with_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    saveGo |-> mmActive);

  // R3
  go_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    saveGo |=> !saveGo);

  // R3
  rise_needs_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mmActive) |-> saveGo);

  // R4
  fall_after_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mmActive) |-> $past(lastRestoreRd));

  // R5
  hold_no_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdReq && mmActive && !lastRestoreRd) |=> mmActive);

  // R8
  take_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HANDLER && takeReq && !resumeReq) |=> state == ST_HANDLER);

  // R9
  order_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    orderErr |=> orderErr);

endmodule

// File: rtl/mm_span_counter.sv
module mm_span_counter #(
  parameter int CNT_W   = 12,
  parameter int MIN_LEN = 161
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  input  logic             latch,
  output logic [CNT_W-1:0] result,
  output logic             short
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_LEN);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntPlus;

  assign cntPlus = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      result <= '0;
      short  <= 1'b0;
    end else begin
      if (clr)      cnt <= '0;
      else if (inc) cnt <= cntPlus;
      if (latch) begin
        result <= cntPlus;
        short  <= cntPlus < MIN_C;
      end
    end
  end

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !latch |=> $stable(result) && $stable(short));

  // R6
  nonzero_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    latch |=> result != '0);

endmodule

// File: rtl/mm_active_seq.sv
module mm_active_seq
  import mm_seq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int ENTRY_MIN = 161,
  parameter int EXIT_MIN  = 258
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             takeReq,
  input  logic             wbEmpty,
  input  logic             firstSaveWr,
  input  logic             saveDone,
  input  logic             resumeReq,
  input  logic             lastRestoreRd,
  input  logic             holdReq,
  output logic             mmActive,
  output logic             saveGo,
  output logic             orderErr,
  output logic             entryShort,
  output logic             exitShort,
  output logic [CNT_W-1:0] entryCycles,
  output logic [CNT_W-1:0] exitCycles
);

  localparam int NUM_SPANS = 2;

  spanStrobes_t strobes;
  logic [NUM_SPANS-1:0] spanClr, spanInc, spanLatch, spanShort;
  logic [CNT_W-1:0]     spanResult [NUM_SPANS];

  mm_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .takeReq(takeReq), .wbEmpty(wbEmpty),
    .firstSaveWr(firstSaveWr), .saveDone(saveDone), .resumeReq(resumeReq),
    .lastRestoreRd(lastRestoreRd), .holdReq(holdReq), .mmActive(mmActive),
    .saveGo(saveGo), .orderErr(orderErr), .strobes(strobes)
  );

  assign spanClr   = {strobes.clrExit,   strobes.clrEntry};
  assign spanInc   = {strobes.incExit,   strobes.incEntry};
  assign spanLatch = {strobes.latchExit, strobes.latchEntry};

  for (genvar g = 0; g < NUM_SPANS; g++) begin : g_span
    localparam int LIMIT = (g == 0) ? ENTRY_MIN : EXIT_MIN;
    mm_span_counter #(.CNT_W(CNT_W), .MIN_LEN(LIMIT)) u_cnt (
      .clk(clk), .rstN(rstN), .clr(spanClr[g]), .inc(spanInc[g]),
      .latch(spanLatch[g]), .result(spanResult[g]), .short(spanShort[g])
    );
  end

  assign entryCycles = spanResult[0];
  assign exitCycles  = spanResult[1];
  assign entryShort  = spanShort[0];
  assign exitShort   = spanShort[1];

endmodule

// File: tb/mm_active_seq_bench.sv
module mm_active_seq_bench;

  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic takeReq = 0, wbEmpty = 0, firstSaveWr = 0, saveDone = 0;
  logic resumeReq = 0, lastRestoreRd = 0, holdReq = 0;
  logic mmActive, saveGo, orderErr, entryShort, exitShort;
  logic [CNT_W-1:0] entryCycles, exitCycles;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mm_active_seq u_mm_active_seq (
    .clk(clk), .rstN(rstN), .takeReq(takeReq), .wbEmpty(wbEmpty),
    .firstSaveWr(firstSaveWr), .saveDone(saveDone), .resumeReq(resumeReq),
    .lastRestoreRd(lastRestoreRd), .holdReq(holdReq), .mmActive(mmActive),
    .saveGo(saveGo), .orderErr(orderErr), .entryShort(entryShort),
    .exitShort(exitShort), .entryCycles(entryCycles), .exitCycles(exitCycles)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Full sequence; entry = drainWaits+1+saveCycles, exit = restoreCycles
  task automatic runSequence(input int drainWaits, input int saveCycles,
                             input int restoreCycles, input bit holdToggle,
                             input bit takeAtEnd);
    int entryExp = drainWaits + 1 + saveCycles;
    takeReq = 1; wbEmpty = 0; tick(); takeReq = 0;
    for (int i = 0; i < drainWaits; i++) begin
      check("R2 active low while draining", mmActive, 0);
      tick();
    end
    wbEmpty = 1; tick(); wbEmpty = 0;
    check("R3 saveGo pulse", saveGo, 1);
    check("R3 active with saveGo", mmActive, 1);
    for (int i = 1; i <= saveCycles; i++) begin
      firstSaveWr = (i == 1);
      saveDone = (i == saveCycles);
      holdReq = holdToggle & i[0];
      tick();
      if (i == 1) check("R3 saveGo single", saveGo, 0);
    end
    firstSaveWr = 0; saveDone = 0;
    check("R6 entry span", entryCycles, entryExp);
    check("R6 entry short flag", entryShort, (entryExp < 161) ? 1 : 0);
    for (int i = 0; i < 5; i++) begin
      holdReq = holdToggle & i[0];
      takeReq = (i == 2);
      tick();
      check("R5/R8 active in handler", mmActive, 1);
    end
    takeReq = 0;
    holdReq = holdToggle;
    resumeReq = 1; tick(); resumeReq = 0;
    check("R10 entry span kept", entryCycles, entryExp);
    for (int i = 1; i <= restoreCycles; i++) begin
      check("R4 active in restore", mmActive, 1);
      lastRestoreRd = (i == restoreCycles);
      takeReq = takeAtEnd && (i == restoreCycles);
      holdReq = holdToggle & i[0];
      tick();
    end
    lastRestoreRd = 0; takeReq = 0; holdReq = 0;
    check("R4 active falls after last read", mmActive, 0);
    check("R7 exit span", exitCycles, restoreCycles);
    check("R7 exit short flag", exitShort, (restoreCycles < 258) ? 1 : 0);
    wbEmpty = 1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R8 no restart after sequence", saveGo, 0);
      check("R8 stays inactive", mmActive, 0);
    end
    wbEmpty = 0;
    check("R10 exit span kept", exitCycles, restoreCycles);
  endtask

  task automatic testReset();
    check("R1 mmActive", mmActive, 0);
    check("R1 saveGo", saveGo, 0);
    check("R1 orderErr", orderErr, 0);
    check("R1 entryShort", entryShort, 0);
    check("R1 exitShort", exitShort, 0);
    check("R1 entryCycles", entryCycles, 0);
    check("R1 exitCycles", exitCycles, 0);
  endtask

  task automatic testShortSpans();
    runSequence(3, 4, 6, 0, 0);
    check("R9 no order error in normal run", orderErr, 0);
  endtask

  task automatic testBoundaries();
    runSequence(60, 100, 258, 1, 0);
    runSequence(59, 100, 257, 0, 0);
  endtask

  task automatic testCollision();
    runSequence(100, 70, 260, 1, 1);
  endtask

  task automatic testOrder();
    firstSaveWr = 1; tick(); firstSaveWr = 0;
    check("R9 order flag set", orderErr, 1);
    tick(); tick();
    check("R9 order flag sticky", orderErr, 1);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    testReset();
    testShortSpans();
    testBoundaries();
    testCollision();
    testOrder();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule